// File: doc/BRIEF.md
# MDIO Management Register Controller

This block is a register-driven master for the two-wire PHY management bus. A CPU-side port exposes two registers. The command register takes one packed word that holds a PHY address, a register number, a read/write opcode and sixteen bits of write data. The PHY-select register holds a 5-bit address for the attached device.

Writing a command starts a full management frame. The frame is clocked out on a divided management clock, with MDIO driven while the clock is low and read data sampled on its rising edge. The same command register reports a busy flag while the frame runs. It reports a read-valid flag, together with the returned data, once a read frame ends.

Software polls busy before it issues the next command. A command written while busy is set is dropped. Read-valid is cleared by every newly accepted command.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Command word (register select 0) fields: write data or read result in bits 15:0, PHY address in bits 20:16, register number in bits 25:21, opcode in bit 26 (1 = read, 0 = write). A write command produces a 64-bit frame, most significant bit first: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits.
- R2: A read command produces the same frame prefix with opcode 10. MDIO output enable stays high for the first 46 bits and is low from the first turnaround bit to the end of the frame.
- R3: During a read, the 16 bits presented on mdio_in in frame bits 48 to 63 are sampled on MDC rising edges, MSB first. When the frame ends, they appear in bits 15:0 of the command word and read-valid (bit 27) is set.
- R4: Busy (bit 28 of the command word) reads 1 from the cycle after a command is accepted until the frame ends, and output enable is low whenever busy is 0.
- R5: A command write while busy is 1 is ignored. The running frame, the stored fields and the final readback are those of the first command.
- R6: Read-valid reads 0 from the cycle after any accepted command, including a write command.
- R7: The PHY-select register (register select 1) stores only bits 4:0 of a write and reads back those bits zero-extended to 32 bits. Writing it does not start a frame.
- R8: MDC idles low. While a frame runs, MDC has a period of CLK_DIV clock cycles with equal low and high halves, and MDIO changes only while MDC is low.
- R9: After a write frame ends, the command word reads back the stored PHY address, register number, opcode and write data with busy and read-valid both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | Register select: 0 command word, 1 PHY-select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_in | input | 1 | Management data from the pad |

## Verification
A bit counter that is off by one shifts every captured frame. It also moves the release of the pad by a bit, which shows in the 64 bits the bench PHY model records at each MDC rising edge during the first affected frame. A stuck busy state shows as a poll that never ends, and an early finish shows as read data missing low bits. Dropped or unguarded command writes appear in the readback of the command word after the frame ends. A wrong clock divider shows up as an MDC period mismatch in the first frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int FRAME_BITS  = 64;
    localparam int CNT_W       = $clog2(FRAME_BITS);
    localparam int TA_POS      = 46;
    localparam int DATA_POS    = 48;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 5;

    localparam int F_DATA_LSB  = 0;
    localparam int F_PHY_LSB   = 16;
    localparam int F_REG_LSB   = 21;
    localparam int F_OP_BIT    = 26;
    localparam int F_RDV_BIT   = 27;
    localparam int F_BUSY_BIT  = 28;

    typedef struct packed {
        logic [ADDR_W-1:0] phy_fld;
        logic [ADDR_W-1:0] reg_fld;
        logic              op_rd;
        logic [DATA_W-1:0] data;
        logic              rd_valid;
        logic [ADDR_W-1:0] phy_sel;
    } regs_t;

    typedef struct packed {
        logic                  busy;
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      bit_cnt;
        logic                  is_rd;
        logic [DATA_W-1:0]     rdsh;
        logic                  mdo;
        logic                  oe;
    } eng_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rga,
        input logic [DATA_W-1:0] wd
    );
        logic [1:0] op;
        op = rd ? 2'b10 : 2'b01;
        return {32'hFFFF_FFFF, 2'b01, op, phy, rga, 2'b10, rd ? 16'h0000 : wd};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int CLK_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int DIV_W = $clog2(CLK_DIV);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d    = gen_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else if (gen_q.cnt == DIV_W'(HALF - 1)) begin
            gen_d.mdc = 1'b1;
            gen_d.cnt = gen_q.cnt + 1'b1;
            rise_stb  = 1'b1;
        end else if (gen_q.cnt == DIV_W'(CLK_DIV - 1)) begin
            gen_d.mdc = 1'b0;
            gen_d.cnt = '0;
            fall_stb  = 1'b1;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc = gen_q.mdc;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [ADDR_W-1:0] start_phy,
    input  logic [ADDR_W-1:0] start_reg,
    input  logic [DATA_W-1:0] start_data,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_in,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] rd_word,
    output logic              mdio_out,
    output logic              mdio_oe
);
    eng_t eng_d, eng_q;
    logic last_bit;
    logic [CNT_W-1:0] nxt_cnt;

    assign last_bit = (eng_q.bit_cnt == CNT_W'(FRAME_BITS - 1));
    assign nxt_cnt  = eng_q.bit_cnt + 1'b1;

    always_comb begin
        logic [FRAME_BITS-1:0] frm;
        eng_d  = eng_q;
        finish = 1'b0;
        frm    = build_frame(start_rd, start_phy, start_reg, start_data);
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy    = 1'b1;
                eng_d.shreg   = frm;
                eng_d.bit_cnt = '0;
                eng_d.is_rd   = start_rd;
                eng_d.rdsh    = '0;
                eng_d.mdo     = frm[FRAME_BITS-1];
                eng_d.oe      = 1'b1;
            end
        end else begin
            if (rise_stb && eng_q.is_rd && (eng_q.bit_cnt >= CNT_W'(DATA_POS)))
                eng_d.rdsh = {eng_q.rdsh[DATA_W-2:0], mdio_in};
            if (fall_stb) begin
                if (last_bit) begin
                    eng_d.busy = 1'b0;
                    eng_d.oe   = 1'b0;
                    eng_d.mdo  = 1'b0;
                    finish     = 1'b1;
                end else begin
                    eng_d.bit_cnt = nxt_cnt;
                    eng_d.shreg   = {eng_q.shreg[FRAME_BITS-2:0], 1'b0};
                    eng_d.mdo     = eng_q.shreg[FRAME_BITS-2];
                    eng_d.oe      = !(eng_q.is_rd && (nxt_cnt >= CNT_W'(TA_POS)));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy     = eng_q.busy;
    assign rd_word  = eng_q.rdsh;
    assign mdio_out = eng_q.mdo;
    assign mdio_oe  = eng_q.oe;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int CLK_DIV = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    regs_t regs_d, regs_q;
    logic busy_w, finish_w, accept_w, cmd_wr_w, rise_w, fall_w;
    logic [DATA_W-1:0] rd_word_w;
    logic [ADDR_W-1:0] cmd_phy_w, cmd_reg_w;

    assign cmd_wr_w  = reg_wr_en && !reg_sel;
    assign accept_w  = cmd_wr_w && !busy_w;
    assign cmd_phy_w = regs_q.phy_fld;
    assign cmd_reg_w = regs_q.reg_fld;

    mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) i_mdc_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_w),
        .mdc      (mdc),
        .rise_stb (rise_w),
        .fall_stb (fall_w)
    );

    mdio_frame_eng i_frame_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept_w),
        .start_rd   (reg_wdata[F_OP_BIT]),
        .start_phy  (reg_wdata[F_PHY_LSB +: ADDR_W]),
        .start_reg  (reg_wdata[F_REG_LSB +: ADDR_W]),
        .start_data (reg_wdata[F_DATA_LSB +: DATA_W]),
        .rise_stb   (rise_w),
        .fall_stb   (fall_w),
        .mdio_in    (mdio_in),
        .busy       (busy_w),
        .finish     (finish_w),
        .rd_word    (rd_word_w),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    always_comb begin
        regs_d = regs_q;
        if (accept_w) begin
            regs_d.phy_fld  = reg_wdata[F_PHY_LSB +: ADDR_W];
            regs_d.reg_fld  = reg_wdata[F_REG_LSB +: ADDR_W];
            regs_d.op_rd    = reg_wdata[F_OP_BIT];
            regs_d.data     = reg_wdata[F_DATA_LSB +: DATA_W];
            regs_d.rd_valid = 1'b0;
        end
        if (finish_w && regs_q.op_rd) begin
            regs_d.data     = rd_word_w;
            regs_d.rd_valid = 1'b1;
        end
        if (reg_wr_en && reg_sel)
            regs_d.phy_sel = reg_wdata[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[ADDR_W-1:0] = regs_q.phy_sel;
        end else begin
            reg_rdata[F_DATA_LSB +: DATA_W] = regs_q.data;
            reg_rdata[F_PHY_LSB +: ADDR_W]  = regs_q.phy_fld;
            reg_rdata[F_REG_LSB +: ADDR_W]  = regs_q.reg_fld;
            reg_rdata[F_OP_BIT]             = regs_q.op_rd;
            reg_rdata[F_RDV_BIT]            = regs_q.rd_valid;
            reg_rdata[F_BUSY_BIT]           = busy_w;
        end
    end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       cmd_wr,
    input logic       rd_valid,
    input logic       mdc,
    input logic       mdio_out,
    input logic       mdio_oe,
    input logic [4:0] cmd_phy,
    input logic [4:0] cmd_reg
);
    p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy);

    p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> ($stable(cmd_phy) && $stable(cmd_reg)));

    p_rdv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> !rd_valid);

    p_mdc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_mdio_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_out));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk i_mdio_mgmt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_w),
    .cmd_wr   (cmd_wr_w),
    .rd_valid (regs_q.rd_valid),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .cmd_phy  (cmd_phy_w),
    .cmd_reg  (cmd_reg_w)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
    localparam int DIV = 8;
    localparam int TCK = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [63:0] cap_o = '0, cap_oe = '0;
    int          pos = 0;
    int          start_pos = 0;
    logic [15:0] phy_rd = '0;
    time         t_prev = 0, t_last = 0;

    always #(TCK/2) clk = ~clk;

    mdio_mgmt_ctrl #(.CLK_DIV(DIV)) i_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always @(posedge mdc) begin
        cap_o  = {cap_o[62:0], mdio_out};
        cap_oe = {cap_oe[62:0], mdio_oe};
        pos    = pos + 1;
        t_prev = t_last;
        t_last = $time;
    end

    always @(negedge mdc) begin
        int idx;
        idx = pos - start_pos;
        if (idx >= 48 && idx < 64) mdio_in = phy_rd[63 - idx];
        else                       mdio_in = 1'b1;
    end

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] rga, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rga, 2'b10, rd ? 16'h0 : d};
    endfunction

    function automatic logic [31:0] cmd_word(input logic rd, input logic [4:0] phy,
                                             input logic [4:0] rga, input logic [15:0] d);
        return {5'b0, rd, rga, phy, d};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rd_reg(1'b0, v);
            if (!v[28]) return;
        end
        check("R4 busy never cleared", 64'd1, 64'd0);
    endtask

    task automatic run_cmd(input logic rd, input logic [4:0] phy, input logic [4:0] rga,
                           input logic [15:0] d, input logic [15:0] phy_data);
        logic [31:0] v;
        logic [63:0] ef;
        phy_rd    = phy_data;
        start_pos = pos;
        wr_reg(1'b0, cmd_word(rd, phy, rga, d));
        rd_reg(1'b0, v);
        check("R4 busy after accept", 64'(v[28]), 64'd1);
        check("R6 read-valid cleared on command", 64'(v[27]), 64'd0);
        wait_idle();
        ef = exp_frame(rd, phy, rga, d);
        rd_reg(1'b0, v);
        if (rd) begin
            check("R2 read frame prefix", cap_o[63:18], ef[63:18]);
            check("R2 read output enable", cap_oe, {{46{1'b1}}, 18'b0});
            check("R3 read data and valid", {32'b0, v}, 64'(cmd_word(1'b1, phy, rga, phy_data) | 32'h0800_0000));
        end else begin
            check("R1 write frame", cap_o, ef);
            check("R1 write output enable", cap_oe, {64{1'b1}});
            check("R9 write readback", {32'b0, v}, 64'(cmd_word(1'b0, phy, rga, d)));
        end
        check("R4 output enable idle", 64'(mdio_oe), 64'd0);
    endtask

    initial begin
        #(200000 * TCK);
        check("watchdog expired", 64'd1, 64'd0);
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(1'b0, v);
        check("R4 reset command word", {32'b0, v}, 64'd0);
        check("R8 reset mdc low", {62'b0, mdc, mdio_oe}, 64'd0);

        // R7: only bits 4:0 kept, no frame started
        wr_reg(1'b1, 32'hFFFF_FFF5);
        rd_reg(1'b1, v);
        check("R7 phy-select readback", {32'b0, v}, 64'h15);
        repeat (DIV) @(negedge clk);
        rd_reg(1'b0, v);
        check("R7 no frame started", {62'b0, v[28], mdc}, 64'd0);

        // R1 directed boundary values
        run_cmd(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0);
        check("R8 mdc period", 64'(t_last - t_prev), 64'(DIV * TCK));
        run_cmd(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0);
        // R3 directed read
        run_cmd(1'b1, 5'd1, 5'd2, 16'h0, 16'hA5C3);

        // R6: a write after a valid read clears read-valid
        run_cmd(1'b0, 5'd3, 5'd4, 16'h1234, 16'h0);

        // R5: command while busy ignored
        phy_rd    = 16'h0;
        start_pos = pos;
        wr_reg(1'b0, cmd_word(1'b0, 5'd9, 5'd10, 16'hBEEF));
        repeat (5) @(negedge clk);
        wr_reg(1'b0, cmd_word(1'b1, 5'd17, 5'd20, 16'h0F0F));
        rd_reg(1'b0, v);
        check("R5 fields unchanged while busy", {32'b0, v}, 64'(cmd_word(1'b0, 5'd9, 5'd10, 16'hBEEF) | 32'h1000_0000));
        wait_idle();
        check("R5 frame of first command", cap_o, exp_frame(1'b0, 5'd9, 5'd10, 16'hBEEF));
        rd_reg(1'b0, v);
        check("R5 final readback", {32'b0, v}, 64'(cmd_word(1'b0, 5'd9, 5'd10, 16'hBEEF)));

        // random mix
        for (int k = 0; k < 12; k++) begin
            logic       rd;
            logic [4:0] ph, rg;
            logic [15:0] d, pd;
            rd = 1'($urandom);
            ph = 5'($urandom);
            rg = 5'($urandom);
            d  = 16'($urandom);
            pd = 16'($urandom);
            run_cmd(rd, ph, rg, d, pd);
        end

        rd_reg(1'b1, v);
        check("R7 phy-select retained", {32'b0, v}, 64'h15);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule